// File: doc/BRIEF.md
# 8-bit Add/Subtract Unit with Status Flags

This block is the arithmetic part of a small byte-wide processor core. It is purely combinational: from an operation code, a destination operand, a source operand (a register value or an immediate, chosen before this block), and the current status byte, it produces a result byte, a write-enable for the register file, and the next status byte. Every operation, including negate, is built on one ripple adder. A subtraction adds the bitwise inverse of the subtrahend plus a carry-in. The flags are then formed from the sign bits and the nibble bits of the operands and the result, using separate equations for the adding and the subtracting operations.

The compare operations produce the same flags as the matching subtractions but clear the write-enable, so the destination register keeps its value. The status byte holds eight bits: C at bit 0, Z at bit 1, N at bit 2, V at bit 3, S at bit 4, H at bit 5, T at bit 6, I at bit 7. Only the lower six bits are recomputed. Bits 6 and 7 pass straight through. The block has no clock and no handshake. The result is valid once the inputs settle, and the enclosing pipeline stage registers it.

Top module: `alu8_core`

## Requirements
- R1: Opcode 0 (add) gives result = dst + src modulo 256 and asserts wr_en.
- R2: Opcode 1 (add with carry) gives result = dst + src + C, where C is status bit 0. It asserts wr_en.
- R3: Opcodes 2 (subtract) and 3 (subtract with carry) give result = dst + ~src + k modulo 256, with k = 1 for opcode 2 and k = ~C for opcode 3. Both assert wr_en.
- R4: For opcodes 0 and 1, with d, r, x the bit 7 of dst, src and result: C = d&r | r&~x | ~x&d and V = d&r&~x | ~d&~r&x. H uses the C equation on bit 3.
- R5: For opcodes 2 to 7, using the same bit names: C = ~d&r | r&x | x&~d and V = d&~r&~x | ~d&r&x. H uses this C equation on bit 3.
- R6: For every opcode, N equals result bit 7, Z is 1 exactly when the result is 0, and S equals N xor V.
- R7: Opcode 4 (compare, k = 1) and opcode 5 (compare with carry, k = ~C) compute flags like subtraction but drive wr_en low.
- R8: Opcode 6 (compare immediate) subtracts with k = 1 whatever the value of C, and drives wr_en low.
- R9: Opcode 7 (negate) computes 0 - dst. It uses dst as the subtrahend, 0 as the minuend and k = 1, ignores src, and asserts wr_en.
- R10: Status bits 6 (T) and 7 (I) are copied from flags_in to flags_out unchanged for every opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 3 | Operation select, encodings as in R1 to R9 |
| dst_opnd | input | 8 | Destination operand (minuend / first addend / negate operand) |
| src_opnd | input | 8 | Source register or immediate operand |
| flags_in | input | 8 | Current status byte (C bit 0 ... I bit 7) |
| result | output | 8 | Computed byte |
| wr_en | output | 1 | High when the result should be written to the destination |
| flags_out | output | 8 | Next status byte |

## Verification
The bench targets the sign and nibble boundaries. These cases are 0x7F+1, 0x80+0x80, 0x80-1 and the negation of 0x80. A design that reused the addition carry or overflow equations for subtraction would report the wrong borrow or overflow there. It also checks the half carry, for example 0x0F+1. Carry-in handling is probed by three contrasts: add-with-carry against plain add, subtract-with-carry with C both set and clear, and compare-immediate with C set. A design that fed C into the compare-immediate, or failed to invert it for the borrowing forms, would be off by one in the result or in Z. Compares are checked for a low write-enable, negate is checked for ignoring src, and T and I are set on several cases to catch a design that clears or reorders the untouched bits.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int STAT_W = 8;

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
  localparam int FL_T = 6;
  localparam int FL_I = 7;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_CMP = 3'd4,
    OP_CMC = 3'd5,
    OP_CMI = 3'd6,
    OP_NEG = 3'd7
  } alu_op_e;

endpackage

// File: rtl/alu8_opnd_sel.sv
// Chooses the adder inputs, carry-in, equation family and write-enable.
module alu8_opnd_sel #(
  parameter int DATA_W = 8
) (
  input  alu8_pkg::alu_op_e  op,
  input  logic [DATA_W-1:0]  dst,
  input  logic [DATA_W-1:0]  src,
  input  logic               c_flag,
  output logic [DATA_W-1:0]  minu,     // first adder input / flag operand d
  output logic [DATA_W-1:0]  subt,     // flag operand r (not inverted)
  output logic [DATA_W-1:0]  addend,   // second adder input
  output logic               cin,
  output logic               is_sub,
  output logic               wr_en
);
  import alu8_pkg::*;

  always_comb begin
    minu   = dst;
    subt   = src;
    cin    = 1'b0;
    is_sub = 1'b0;
    wr_en  = 1'b1;
    unique case (op)
      OP_ADD: cin = 1'b0;
      OP_ADC: cin = c_flag;
      OP_SUB: begin is_sub = 1'b1; cin = 1'b1; end
      OP_SBC: begin is_sub = 1'b1; cin = ~c_flag; end
      OP_CMP: begin is_sub = 1'b1; cin = 1'b1;    wr_en = 1'b0; end
      OP_CMC: begin is_sub = 1'b1; cin = ~c_flag; wr_en = 1'b0; end
      OP_CMI: begin is_sub = 1'b1; cin = 1'b1;    wr_en = 1'b0; end
      OP_NEG: begin
        is_sub = 1'b1;
        cin    = 1'b1;
        minu   = '0;
        subt   = dst;
      end
      default: cin = 1'b0;
    endcase
    addend = is_sub ? ~subt : subt;
  end

endmodule

// File: rtl/alu8_ripple_add.sv
// Plain ripple-carry adder, one full-adder cell per bit.
module alu8_ripple_add #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] sum
);
  logic [DATA_W:0] cy;

  assign cy[0] = cin;

  for (genvar i = 0; i < DATA_W; i++) begin : g_cell
    assign sum[i]  = a[i] ^ b[i] ^ cy[i];
    assign cy[i+1] = (a[i] & b[i]) | (a[i] & cy[i]) | (b[i] & cy[i]);
  end

endmodule

// File: rtl/alu8_flag_eval.sv
// Status bits from operand and result bits.
module alu8_flag_eval #(
  parameter int DATA_W   = 8,
  parameter int HALF_BIT = 3
) (
  input  logic [DATA_W-1:0]          d_op,
  input  logic [DATA_W-1:0]          r_op,
  input  logic [DATA_W-1:0]          res,
  input  logic                       is_sub,
  input  logic [alu8_pkg::STAT_W-1:0] st_in,
  output logic [alu8_pkg::STAT_W-1:0] st_out
);
  import alu8_pkg::*;

  localparam int MSB = DATA_W - 1;

  function automatic logic carry_add(input logic d, input logic r, input logic x);
    return (d & r) | (r & ~x) | (~x & d);
  endfunction

  function automatic logic carry_sub(input logic d, input logic r, input logic x);
    return (~d & r) | (r & x) | (x & ~d);
  endfunction

  logic c_f, h_f, v_f, n_f, z_f, s_f;

  always_comb begin
    if (is_sub) begin
      c_f = carry_sub(d_op[MSB], r_op[MSB], res[MSB]);
      h_f = carry_sub(d_op[HALF_BIT], r_op[HALF_BIT], res[HALF_BIT]);
      v_f = (d_op[MSB] & ~r_op[MSB] & ~res[MSB]) | (~d_op[MSB] & r_op[MSB] & res[MSB]);
    end else begin
      c_f = carry_add(d_op[MSB], r_op[MSB], res[MSB]);
      h_f = carry_add(d_op[HALF_BIT], r_op[HALF_BIT], res[HALF_BIT]);
      v_f = (d_op[MSB] & r_op[MSB] & ~res[MSB]) | (~d_op[MSB] & ~r_op[MSB] & res[MSB]);
    end
    n_f = res[MSB];
    z_f = ~|res;
    s_f = n_f ^ v_f;

    st_out       = st_in;
    st_out[FL_C] = c_f;
    st_out[FL_Z] = z_f;
    st_out[FL_N] = n_f;
    st_out[FL_V] = v_f;
    st_out[FL_S] = s_f;
    st_out[FL_H] = h_f;
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int DATA_W   = 8,
  parameter int HALF_BIT = 3
) (
  input  logic [2:0]        op_code,
  input  logic [DATA_W-1:0] dst_opnd,
  input  logic [DATA_W-1:0] src_opnd,
  input  logic [7:0]        flags_in,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic [7:0]        flags_out
);
  import alu8_pkg::*;

  alu_op_e           op;
  logic [DATA_W-1:0] d_op, r_op, b_op, sum;
  logic              cin, is_sub;

  assign op = alu_op_e'(op_code);

  alu8_opnd_sel #(.DATA_W(DATA_W)) sel_i (
    .op     (op),
    .dst    (dst_opnd),
    .src    (src_opnd),
    .c_flag (flags_in[FL_C]),
    .minu   (d_op),
    .subt   (r_op),
    .addend (b_op),
    .cin    (cin),
    .is_sub (is_sub),
    .wr_en  (wr_en)
  );

  alu8_ripple_add #(.DATA_W(DATA_W)) add_i (
    .a   (d_op),
    .b   (b_op),
    .cin (cin),
    .sum (sum)
  );

  alu8_flag_eval #(.DATA_W(DATA_W), .HALF_BIT(HALF_BIT)) flg_i (
    .d_op   (d_op),
    .r_op   (r_op),
    .res    (sum),
    .is_sub (is_sub),
    .st_in  (flags_in),
    .st_out (flags_out)
  );

  assign result = sum;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int DATA_W   = 8,
  parameter int HALF_BIT = 3
) (
  input logic [2:0]        op_code,
  input logic [DATA_W-1:0] dst_opnd,
  input logic [DATA_W-1:0] src_opnd,
  input logic [7:0]        flags_in,
  input logic [DATA_W-1:0] result,
  input logic              wr_en,
  input logic [7:0]        flags_out
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] exp_diff, exp_sum, exp_neg;
  assign exp_diff = dst_opnd - src_opnd;
  assign exp_sum  = dst_opnd + src_opnd;
  assign exp_neg  = DATA_W'(0) - dst_opnd;

  always_comb begin
    if (op_code == 3'd0)
      p_add_sum_r1: assert (result == exp_sum);
    if (op_code == 3'd2 || op_code == 3'd4)
      p_sub_diff_r3: assert (result == exp_diff);
    if (op_code >= 3'd4 && op_code <= 3'd6)
      p_cmp_no_write_r7: assert (!wr_en);
    if (op_code == 3'd6)
      p_cmi_no_carry_r8: assert (result == exp_diff);
    if (op_code == 3'd7)
      p_neg_value_r9: assert (result == exp_neg && wr_en);
    p_zero_match_r6: assert (flags_out[1] == (result == '0));
    p_sign_xor_r6: assert (flags_out[4] == (flags_out[2] ^ flags_out[3]));
    p_neg_bit_r6: assert (flags_out[2] == result[MSB]);
    p_keep_ti_r10: assert (flags_out[7:6] == flags_in[7:6]);
    p_half_bit_dep_r4: assert (HALF_BIT < DATA_W);
  end

endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W), .HALF_BIT(HALF_BIT)) chk_i (
  .op_code   (op_code),
  .dst_opnd  (dst_opnd),
  .src_opnd  (src_opnd),
  .flags_in  (flags_in),
  .result    (result),
  .wr_en     (wr_en),
  .flags_out (flags_out)
);

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;

  logic       clk = 1'b0;
  logic [2:0] op_code  = '0;
  logic [7:0] dst_opnd = '0;
  logic [7:0] src_opnd = '0;
  logic [7:0] flags_in = '0;
  logic [7:0] result;
  logic       wr_en;
  logic [7:0] flags_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  alu8_core dut_i (
    .op_code   (op_code),
    .dst_opnd  (dst_opnd),
    .src_opnd  (src_opnd),
    .flags_in  (flags_in),
    .result    (result),
    .wr_en     (wr_en),
    .flags_out (flags_out)
  );

  typedef struct {
    logic [7:0] res;
    logic       we;
    logic [7:0] fl;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  task automatic check8(input string tag, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", tag, what, act, exp);
    end
  endtask

  // Driver: applies a case on the falling edge and queues its expectation.
  task automatic send(input logic [2:0] op, input logic [7:0] d, input logic [7:0] s,
                      input logic [7:0] fi, input logic [7:0] eres, input logic ewe,
                      input logic [7:0] efl, input string tag);
    exp_t e;
    @(negedge clk);
    op_code  = op;
    dst_opnd = d;
    src_opnd = s;
    flags_in = fi;
    e.res = eres; e.we = ewe; e.fl = efl; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: compares on the rising edge, half a period after the drive.
  always @(posedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check8(e.tag, "result", result, e.res);
      check8(e.tag, "wr_en", {7'd0, wr_en}, {7'd0, e.we});
      check8(e.tag, "flags", flags_out, e.fl);
    end
  end

  initial begin
    // idle state: all-zero inputs (R6)
    send(3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'h02, "R6 idle");
    send(3'd0, 8'h0F, 8'h01, 8'h00, 8'h10, 1'b1, 8'h20, "R1/R4 half");
    send(3'd0, 8'h80, 8'h80, 8'h00, 8'h00, 1'b1, 8'h1B, "R1/R4 wrap");
    send(3'd0, 8'h7F, 8'h01, 8'hC0, 8'h80, 1'b1, 8'hEC, "R4/R10 ovf");
    send(3'd1, 8'hFF, 8'h00, 8'h01, 8'h00, 1'b1, 8'h23, "R2 carry");
    send(3'd1, 8'h10, 8'h20, 8'hC0, 8'h30, 1'b1, 8'hC0, "R2/R10 noc");
    send(3'd1, 8'h10, 8'h20, 8'h01, 8'h31, 1'b1, 8'h00, "R2 plus1");
    send(3'd2, 8'h0F, 8'h10, 8'h00, 8'hFF, 1'b1, 8'h15, "R5 borrow");
    send(3'd2, 8'h80, 8'h01, 8'h00, 8'h7F, 1'b1, 8'h38, "R5 ovf");
    send(3'd2, 8'h42, 8'h42, 8'h00, 8'h00, 1'b1, 8'h02, "R3 equal");
    send(3'd3, 8'h00, 8'h00, 8'h01, 8'hFF, 1'b1, 8'h35, "R3 sbc c1");
    send(3'd3, 8'h50, 8'h10, 8'h00, 8'h40, 1'b1, 8'h00, "R3 sbc c0");
    send(3'd4, 8'h05, 8'h03, 8'h00, 8'h02, 1'b0, 8'h00, "R7 cmp gt");
    send(3'd4, 8'h03, 8'h05, 8'h00, 8'hFE, 1'b0, 8'h35, "R7 cmp lt");
    send(3'd5, 8'h10, 8'h10, 8'h01, 8'hFF, 1'b0, 8'h35, "R7 cmc");
    send(3'd6, 8'h10, 8'h10, 8'h41, 8'h00, 1'b0, 8'h42, "R8/R10 cmi");
    send(3'd6, 8'h05, 8'h03, 8'h01, 8'h02, 1'b0, 8'h00, "R8 cmi c1");
    send(3'd7, 8'h01, 8'h00, 8'h00, 8'hFF, 1'b1, 8'h35, "R9 neg1");
    send(3'd7, 8'h80, 8'h00, 8'h00, 8'h80, 1'b1, 8'h0D, "R9 neg80");
    send(3'd7, 8'h00, 8'h55, 8'h81, 8'h00, 1'b1, 8'h82, "R9/R10 neg0");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule